// File: doc/BRIEF.md
# Adapter Control Register Bank

This block is the register file behind the control window of a paravirtual network adapter. A host driver reaches it through a simple 32-bit memory-mapped access port. The bank holds a hardware version word, an error word, a 64-bit pointer to a region of memory shared with the host, a control word, a request word and an interrupt mask. Reads of a mapped offset return the value held there.

Certain writes have side effects. These are reported to the rest of the adapter as one-cycle strobes. The adapter then does the real work of mapping the shared region, activating the device, leaving quiesce, resetting, or running a queued command. The shared-region pointer is written in two halves. Writing the upper half starts a short sequencer that runs through the states SEQ_IDLE, SEQ_LOAD and SEQ_CAPS.

The sequencer moves from SEQ_IDLE to SEQ_LOAD on an upper-half write. It moves from SEQ_LOAD to SEQ_CAPS when no new upper-half write arrives, and from SEQ_CAPS back to SEQ_IDLE. An upper-half write seen in SEQ_LOAD or SEQ_CAPS sends the sequencer back to SEQ_LOAD. The load strobe is high in SEQ_LOAD and the capability strobe is high in SEQ_CAPS.

Top module: `ctl_regbank`

## Requirements
- R1: After reset, offset 0x00 reads the HW_VERSION parameter (default 0x00000017) and offset 0x14 reads 0x0000FFFF. The control, request and mask words and the 64-bit region pointer read zero, and no strobe is high.
- R2: A full write to offset 0x04 replaces the whole region pointer with the zero-extended write data, so the upper 32 bits become zero.
- R3: A full write to offset 0x08 ORs the write data, shifted left by 32, into the region pointer. Offset 0x04 reads the pointer's bits 31:0 and offset 0x08 reads bits 63:32.
- R4: In the cycle after an upper-half write, load_pulse is high for one cycle. caps_pulse is high in the cycle after that, unless another upper-half write arrived in the load cycle; in that case the load cycle repeats and no caps cycle occurs yet.
- R5: A full write to the control offset 0x0C raises one strobe for one cycle, in the cycle after the write. Code 1 raises activate_pulse, code 2 raises unquiesce_pulse and code 3 raises reset_pulse. Any other value raises no strobe. The written value is always stored and reads back.
- R6: Writing code 1 to offset 0x0C sets the error word (offset 0x14) to zero in the same cycle that activate_pulse rises.
- R7: A full write of zero to the request offset 0x10 raises exec_pulse for one cycle, in the cycle after the write. A nonzero value raises nothing. Both values are stored and read back.
- R8: A full write to offset 0x1C stores the value as the interrupt mask, which appears on irq_mask in the following cycle. Offset 0x14 is also writable.
- R9: An access whose byte enables are not all ones is rejected. It changes no register and raises no strobe. In the next cycle it raises bus_err, and if it was a read, bus_rdata is all ones.
- R10: A read of an offset other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14 or 0x1C returns all ones with a one-cycle bus_err. This includes misaligned offsets. A write to such an offset changes nothing and raises no error. A write to 0x00 is ignored.
- R11: A read's data and bus_rvalid appear in the cycle after the access. bus_rdata is zero in any cycle without a read response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_be | input | DATA_W/8 | Byte enables; only all ones is accepted |
| bus_wdata | input | DATA_W | Write data, little-endian |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | DATA_W | Read response data |
| bus_err | output | 1 | One-cycle error for a rejected or unmapped access |
| region_addr | output | 2*DATA_W | Current shared-region pointer |
| irq_mask | output | DATA_W | Current interrupt mask |
| load_pulse | output | 1 | Map the shared region |
| caps_pulse | output | 1 | Fill in the capabilities in the shared region |
| activate_pulse | output | 1 | Activate the device |
| unquiesce_pulse | output | 1 | Leave quiesce |
| reset_pulse | output | 1 | Reset the device |
| exec_pulse | output | 1 | Run the posted command |

## Verification
The hardest case to reach from the ports is an upper-half pointer write that lands while the sequencer is already in SEQ_LOAD or SEQ_CAPS. A single write always runs the whole load-then-capability pair. The restart path is only exercised when a second upper-half write follows in the very next cycle, or one cycle later. The stimulus issues such writes back to back and with a one-cycle gap. The bench's behavioural model predicts whether the capability strobe is skipped or still fires. The strobes and the pointer's OR accumulation are compared against that model every cycle.

// File: rtl/ctlbank_pkg.sv
package ctlbank_pkg;

    // Register offsets (bytes)
    localparam int OFF_VERSION = 'h00;
    localparam int OFF_PTR_LO  = 'h04;
    localparam int OFF_PTR_HI  = 'h08;
    localparam int OFF_CONTROL = 'h0C;
    localparam int OFF_REQUEST = 'h10;
    localparam int OFF_ERROR   = 'h14;
    localparam int OFF_MASK    = 'h1C;

    // Control codes: code value = index + 1
    localparam int NUM_CODES   = 3;
    localparam int IDX_ACT     = 0;
    localparam int IDX_UNQ     = 1;
    localparam int IDX_RST     = 2;

    localparam logic [31:0] ERROR_RESET = 32'h0000_FFFF;

    typedef enum logic [2:0] {
        SEL_VERSION,
        SEL_PTR_LO,
        SEL_PTR_HI,
        SEL_CONTROL,
        SEL_REQUEST,
        SEL_ERROR,
        SEL_MASK,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD,
        SEQ_CAPS
    } seq_state_e;

endpackage

// File: rtl/ctlbank_decode.sv
module ctlbank_decode
    import ctlbank_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_e          sel_o
);

    always_comb begin
        unique case (addr_i)
            ADDR_W'(OFF_VERSION): sel_o = SEL_VERSION;
            ADDR_W'(OFF_PTR_LO):  sel_o = SEL_PTR_LO;
            ADDR_W'(OFF_PTR_HI):  sel_o = SEL_PTR_HI;
            ADDR_W'(OFF_CONTROL): sel_o = SEL_CONTROL;
            ADDR_W'(OFF_REQUEST): sel_o = SEL_REQUEST;
            ADDR_W'(OFF_ERROR):   sel_o = SEL_ERROR;
            ADDR_W'(OFF_MASK):    sel_o = SEL_MASK;
            default:              sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/ctlbank_seq.sv
module ctlbank_seq
    import ctlbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_wr_i,
    output logic load_o,
    output logic caps_o
);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: if (hi_wr_i) state_d = SEQ_LOAD;
            SEQ_LOAD: state_d = hi_wr_i ? SEQ_LOAD : SEQ_CAPS;
            SEQ_CAPS: state_d = hi_wr_i ? SEQ_LOAD : SEQ_IDLE;
            default:  state_d = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        load_o = 1'b0;
        caps_o = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_LOAD: load_o = 1'b1;
            SEQ_CAPS: caps_o = 1'b1;
            default:  ;
        endcase
    end

    // R4: a load cycle is always caused by an upper-half write one cycle earlier
    a_r4_load_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> $past(hi_wr_i));

    // R4: an undisturbed load cycle is followed by the capability cycle
    a_r4_caps_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_o && !hi_wr_i) |=> caps_o);

endmodule

// File: rtl/ctlbank_cmd.sv
module ctlbank_cmd
    import ctlbank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic              req_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              act_now_o,
    output logic [NUM_CODES-1:0] code_pulse_o,
    output logic              exec_o
);

    logic [NUM_CODES-1:0] hit;

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_code
        assign hit[i] = ctl_wr_i && (wdata_i == DATA_W'(i + 1));
    end

    assign act_now_o = hit[IDX_ACT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_pulse_o <= '0;
            exec_o       <= 1'b0;
        end else begin
            code_pulse_o <= hit;
            exec_o       <= req_wr_i && (wdata_i == '0);
        end
    end

    // R5: at most one control action at a time
    a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(code_pulse_o));

    // R7: execution strobe only after a zero write to the request word
    a_r7_exec_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        exec_o |-> ($past(req_wr_i) && $past(wdata_i) == '0));

endmodule

// File: rtl/ctl_regbank.sv
module ctl_regbank
    import ctlbank_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          ADDR_W     = 5,
    parameter logic [31:0] HW_VERSION = 32'h0000_0017,
    localparam int         BE_W       = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BE_W-1:0]     bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                bus_rvalid,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_err,
    output logic [2*DATA_W-1:0] region_addr,
    output logic [DATA_W-1:0]   irq_mask,
    output logic                load_pulse,
    output logic                caps_pulse,
    output logic                activate_pulse,
    output logic                unquiesce_pulse,
    output logic                reset_pulse,
    output logic                exec_pulse
);

    reg_sel_e             sel;
    logic                 full_acc, wr_ok, rd_ok;
    logic                 act_now;
    logic [NUM_CODES-1:0] code_pulse;
    logic [DATA_W-1:0]    err_q, ctl_q, req_q, mask_q, rd_val;
    logic [2*DATA_W-1:0]  ptr_q;

    assign full_acc = &bus_be;
    assign wr_ok    = bus_valid && bus_write && full_acc;
    assign rd_ok    = bus_valid && !bus_write && full_acc;

    ctlbank_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .sel_o  (sel)
    );

    ctlbank_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .hi_wr_i (wr_ok && sel == SEL_PTR_HI),
        .load_o  (load_pulse),
        .caps_o  (caps_pulse)
    );

    ctlbank_cmd #(.DATA_W(DATA_W)) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctl_wr_i     (wr_ok && sel == SEL_CONTROL),
        .req_wr_i     (wr_ok && sel == SEL_REQUEST),
        .wdata_i      (bus_wdata),
        .act_now_o    (act_now),
        .code_pulse_o (code_pulse),
        .exec_o       (exec_pulse)
    );

    assign activate_pulse  = code_pulse[IDX_ACT];
    assign unquiesce_pulse = code_pulse[IDX_UNQ];
    assign reset_pulse     = code_pulse[IDX_RST];
    assign region_addr     = ptr_q;
    assign irq_mask        = mask_q;

    // Register storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q  <= DATA_W'(ERROR_RESET);
            ctl_q  <= '0;
            req_q  <= '0;
            mask_q <= '0;
            ptr_q  <= '0;
        end else if (wr_ok) begin
            case (sel)
                SEL_PTR_LO:  ptr_q  <= {{DATA_W{1'b0}}, bus_wdata};
                SEL_PTR_HI:  ptr_q  <= ptr_q | {bus_wdata, {DATA_W{1'b0}}};
                SEL_CONTROL: begin
                    ctl_q <= bus_wdata;
                    if (act_now) err_q <= '0;
                end
                SEL_REQUEST: req_q  <= bus_wdata;
                SEL_ERROR:   err_q  <= bus_wdata;
                SEL_MASK:    mask_q <= bus_wdata;
                default:     ;
            endcase
        end
    end

    // Read selection
    always_comb begin
        unique case (sel)
            SEL_VERSION: rd_val = DATA_W'(HW_VERSION);
            SEL_PTR_LO:  rd_val = ptr_q[DATA_W-1:0];
            SEL_PTR_HI:  rd_val = ptr_q[2*DATA_W-1:DATA_W];
            SEL_CONTROL: rd_val = ctl_q;
            SEL_REQUEST: rd_val = req_q;
            SEL_ERROR:   rd_val = err_q;
            SEL_MASK:    rd_val = mask_q;
            default:     rd_val = '1;
        endcase
    end

    // Response stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
            bus_err    <= 1'b0;
        end else begin
            bus_rvalid <= bus_valid && !bus_write;
            if (bus_valid && !bus_write)
                bus_rdata <= rd_ok ? rd_val : '1;
            else
                bus_rdata <= '0;
            bus_err <= bus_valid && (!full_acc || (!bus_write && sel == SEL_NONE));
        end
    end

    // R6: activation leaves the error word cleared
    a_r6_act_clears_err: assert property (@(posedge clk) disable iff (!rst_n)
        activate_pulse |-> (err_q == '0));

    // R9: a partial access leaves pointer and mask untouched
    a_r9_partial_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !full_acc) |=> ($stable(region_addr) && $stable(irq_mask)));

    // R10: an error flag always answers an access of the previous cycle
    a_r10_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_valid));

    // R11: read data is zero outside a read response
    a_r11_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rvalid |-> (bus_rdata == '0));

endmodule

// File: tb/sim_ctl_regbank.sv
module sim_ctl_regbank;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rvalid, bus_err;
    logic [31:0] bus_rdata, irq_mask;
    logic [63:0] region_addr;
    logic        load_pulse, caps_pulse, activate_pulse, unquiesce_pulse, reset_pulse, exec_pulse;

    int checks = 0;
    int failures = 0;
    int cyc_cnt = 0;
    bit done = 0;

    // Behavioural model state
    logic [31:0] m_err = 32'hFFFF, m_ctl = 0, m_req = 0, m_mask = 0;
    logic [63:0] m_ptr = 0;
    logic        e_rvalid = 0, e_err = 0, e_load = 0, e_caps = 0, e_act = 0, e_unq = 0, e_rst = 0, e_exec = 0;
    logic [31:0] e_rdata = 0;

    ctl_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .region_addr(region_addr), .irq_mask(irq_mask),
        .load_pulse(load_pulse), .caps_pulse(caps_pulse),
        .activate_pulse(activate_pulse), .unquiesce_pulse(unquiesce_pulse),
        .reset_pulse(reset_pulse), .exec_pulse(exec_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a, output bit hit);
        hit = 1;
        case (a)
            5'h00: return 32'h0000_0017;
            5'h04: return m_ptr[31:0];
            5'h08: return m_ptr[63:32];
            5'h0C: return m_ctl;
            5'h10: return m_req;
            5'h14: return m_err;
            5'h1C: return m_mask;
            default: begin hit = 0; return 32'hFFFF_FFFF; end
        endcase
    endfunction

    task automatic compare_all();
        chk("R11 rvalid",          {63'b0, bus_rvalid},      {63'b0, e_rvalid});
        chk("R11/R1/R10 rdata",    {32'b0, bus_rdata},       {32'b0, e_rdata});
        chk("R9/R10 bus_err",      {63'b0, bus_err},         {63'b0, e_err});
        chk("R2/R3 region_addr",   region_addr,              m_ptr);
        chk("R8 irq_mask",         {32'b0, irq_mask},        {32'b0, m_mask});
        chk("R4 load_pulse",       {63'b0, load_pulse},      {63'b0, e_load});
        chk("R4 caps_pulse",       {63'b0, caps_pulse},      {63'b0, e_caps});
        chk("R5/R6 activate",      {63'b0, activate_pulse},  {63'b0, e_act});
        chk("R5 unquiesce",        {63'b0, unquiesce_pulse}, {63'b0, e_unq});
        chk("R5 reset",            {63'b0, reset_pulse},     {63'b0, e_rst});
        chk("R7 exec",             {63'b0, exec_pulse},      {63'b0, e_exec});
    endtask

    // One bus cycle: drive, predict, clock, compare
    task automatic cyc(input bit v, input bit w, input logic [4:0] a,
                       input logic [3:0] be, input logic [31:0] d);
        bit hit, full, hiw;
        logic [31:0] rv;
        bus_valid = v; bus_write = w; bus_addr = a; bus_be = be; bus_wdata = d;
        full = (be == 4'hF);
        rv   = m_read(a, hit);
        hiw  = v && w && full && a == 5'h08;
        e_caps   = e_load && !hiw;
        e_load   = hiw;
        e_rvalid = v && !w;
        e_rdata  = (v && !w) ? (full ? rv : 32'hFFFF_FFFF) : 32'h0;
        e_err    = v && (!full || (!w && !hit));
        e_act = 0; e_unq = 0; e_rst = 0; e_exec = 0;
        if (v && w && full) begin
            case (a)
                5'h04: m_ptr = {32'h0, d};
                5'h08: m_ptr = m_ptr | {d, 32'h0};
                5'h0C: begin
                    m_ctl = d;
                    if (d == 1) begin e_act = 1; m_err = 0; end
                    if (d == 2) e_unq = 1;
                    if (d == 3) e_rst = 1;
                end
                5'h10: begin m_req = d; e_exec = (d == 0); end
                5'h14: m_err = d;
                5'h1C: m_mask = d;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d); cyc(1, 1, a, 4'hF, d); endtask
    task automatic rd(input logic [4:0] a); cyc(1, 0, a, 4'hF, 0); endtask
    task automatic idle(); cyc(0, 0, 0, 0, 0); endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        compare_all();
        rst_n = 1'b1;
        idle();
        // R1: version and error words after reset
        rd(5'h00); rd(5'h14); rd(5'h0C); rd(5'h10); rd(5'h04); rd(5'h08);
        // R8 / R11: mask store and readback
        wr(5'h1C, 32'hA5A5_0F0F); rd(5'h1C); idle();
        // R2 / R3: pointer halves, R4 single load then caps
        wr(5'h04, 32'h1234_5678); wr(5'h08, 32'h0000_00AB); idle(); idle();
        rd(5'h04); rd(5'h08);
        wr(5'h08, 32'h0000_0100); idle(); idle(); rd(5'h08);
        // R2: low write clears the upper half
        wr(5'h04, 32'h0000_0042); rd(5'h08);
        // R4: back-to-back upper writes restart load, gap of one lets caps collide
        wr(5'h08, 32'h1); wr(5'h08, 32'h2); idle(); idle();
        wr(5'h08, 32'h4); idle(); wr(5'h08, 32'h8); idle(); idle(); idle();
        // R8: error word writable; R5 codes; R6 activate clears error
        wr(5'h14, 32'h0000_0055); rd(5'h14);
        wr(5'h0C, 32'h2); wr(5'h0C, 32'h3); wr(5'h0C, 32'h7); rd(5'h14); rd(5'h0C);
        wr(5'h0C, 32'h1); rd(5'h14); rd(5'h0C); idle();
        // R7: request zero executes, nonzero does not
        wr(5'h10, 32'h0); wr(5'h10, 32'h5); rd(5'h10); wr(5'h10, 32'h0); idle();
        // R9: partial accesses rejected
        cyc(1, 1, 5'h1C, 4'h3, 32'hDEAD_BEEF); rd(5'h1C);
        cyc(1, 1, 5'h0C, 4'h7, 32'h1);         rd(5'h14);
        cyc(1, 1, 5'h08, 4'hE, 32'hFFFF_FFFF); idle();
        cyc(1, 0, 5'h00, 4'h1, 0); idle();
        // R10: unmapped and misaligned reads, unmapped and version writes
        rd(5'h18); rd(5'h02); rd(5'h1F);
        wr(5'h18, 32'h1234); wr(5'h00, 32'hFFFF); rd(5'h00); rd(5'h1C);
        idle(); idle();
        finish_run();
    end

endmodule